// File: doc/BRIEF.md
# MII Receive Front End with Start-Delimiter Hunt

This block sits at the entry of an Ethernet receive path. It takes the 4-bit receive nibbles, the receive-valid strobe and the receive-error strobe that arrive on the receive clock of a media-independent interface. Every nibble is captured into a one-deep staging register. That register feeds a side tap that runs continuously, for use by delimiter and address logic, and also feeds a gated port toward a downstream FIFO.

A four-state sequencer watches the valid and error strobes. When valid rises, the sequencer asks the matcher to hunt for the delimiter nibble 1011 on the side tap. It withdraws the request once the match pulse comes back. It then opens the FIFO port for the rest of the frame. An error closes the port, and the sequencer waits for valid to fall. A loss of valid also closes the port and returns the sequencer to idle.

The block handles nibbles only. Address comparison, length checks, CRC checks and the FIFO itself are left to neighbouring blocks.

Top module: `mii_rx_front`

## Requirements
- R1: While reset is asserted, and for the synchronizer cycles after its release, side_nib, fifo_nib, fifo_vld, sfd_det and sfd_hunt are all 0.
- R2: After each rising clock edge out of reset, side_nib equals the mii_rxd value sampled at that edge, whatever the state of valid, error or forwarding.
- R3: Whenever fifo_vld is 0, fifo_nib is 0000.
- R4: sfd_det is high only while sfd_hunt is high. A 1011 nibble on side_nib has no effect on sfd_det while idle, after an error, or while forwarding.
- R5: sfd_det is a one-cycle pulse. It occurs exactly once in a frame whose delimiter 1011 is reached with no earlier error or loss of valid. sfd_hunt is high in the cycle of the pulse and low in the cycle after it.
- R6: The nibbles presented with fifo_vld high are exactly the nibbles sampled after the delimiter, in order, one per cycle. The delimiter and every nibble before it are never presented.
- R7: A nibble sampled with mii_rx_er high is not forwarded. Nothing more from that frame is forwarded, and an error during the hunt produces no sfd_det.
- R8: A nibble sampled with mii_rx_dv low is never forwarded, and forwarding stops at that edge.
- R9: If mii_rx_dv falls during the hunt, before the delimiter, the block returns to idle. sfd_det does not pulse and nothing is forwarded. The next frame is then received normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_rxd | input | NIB_W | Receive nibble |
| mii_rx_dv | input | 1 | Receive data valid |
| mii_rx_er | input | 1 | Receive error |
| side_nib | output | NIB_W | Staged nibble, continuously updated |
| fifo_nib | output | NIB_W | Staged nibble toward the FIFO, zero when not valid |
| fifo_vld | output | 1 | FIFO port valid (forwarding enabled) |
| sfd_det | output | 1 | Delimiter detected pulse |
| sfd_hunt | output | 1 | Delimiter hunt request from the sequencer |

## Verification
The hardest situations to reach are the edges right around the delimiter. One is an error or a loss of valid on the very nibble after 1011, so the match pulse occurs but nothing is forwarded. The other is an error or a loss of valid while the hunt is still in progress. Directed frames place the error and the valid drop at exactly those nibble positions. Random frames then vary the preamble length, the preamble nibble values (never 1011), the payload length, and the error position. Idle gaps carry 1011 nibbles with valid low, to show that the matcher stays silent outside the hunt.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_RECV = 2'd2,
    ST_DROP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/mii_nibble_stage.sv
module mii_nibble_stage #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] rx_nib,
  input  logic             fwd_en,
  output logic [NIB_W-1:0] side_nib,
  output logic [NIB_W-1:0] fifo_nib,
  output logic             fifo_vld
);
  logic [NIB_W-1:0] stage_q;

  // staging register: loads every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= rx_nib;
    end
  end

  assign side_nib = stage_q;
  assign fifo_nib = fwd_en ? stage_q : '0;
  assign fifo_vld = fwd_en;

  // R2: side tap follows the sampled nibble one edge later
  assert_side_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (side_nib == $past(rx_nib)));
endmodule

// File: rtl/mii_delim_match.sv
module mii_delim_match #(
  parameter int               NIB_W = 4,
  parameter logic [NIB_W-1:0] DELIM = 4'b1011
) (
  input  logic             hunt_req,
  input  logic [NIB_W-1:0] side_nib,
  output logic             det
);
  always_comb begin
    det = 1'b0;
    if (hunt_req) begin
      det = (side_nib == DELIM);
    end
  end
endmodule

// File: rtl/mii_rx_ctrl.sv
module mii_rx_ctrl
  import mii_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_dv,
  input  logic rx_er,
  input  logic det,
  output logic hunt_req,
  output logic fwd_en
);
  rx_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (rx_dv) st_d = rx_er ? ST_DROP : ST_HUNT;
      ST_HUNT: begin
        if (!rx_dv)     st_d = ST_IDLE;
        else if (rx_er) st_d = ST_DROP;
        else if (det)   st_d = ST_RECV;
      end
      ST_RECV: begin
        if (!rx_dv)     st_d = ST_IDLE;
        else if (rx_er) st_d = ST_DROP;
      end
      ST_DROP: if (!rx_dv) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign hunt_req = (st_q == ST_HUNT);
  assign fwd_en   = (st_q == ST_RECV);

  assert_det_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> !det);
  assert_det_drops_hunt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    det |=> !hunt_req);
  assert_fwd_after_det_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_en) |-> $past(det));
  assert_err_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && rx_er) |=> !fwd_en);
  assert_dv_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv |=> !fwd_en);
  assert_hunt_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hunt_req && !rx_dv) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/mii_rx_front.sv
module mii_rx_front #(
  parameter int               NIB_W = 4,
  parameter logic [NIB_W-1:0] DELIM = 4'b1011,
  parameter int               SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] mii_rxd,
  input  logic             mii_rx_dv,
  input  logic             mii_rx_er,
  output logic [NIB_W-1:0] side_nib,
  output logic [NIB_W-1:0] fifo_nib,
  output logic             fifo_vld,
  output logic             sfd_det,
  output logic             sfd_hunt
);
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;
  logic              fwd_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  mii_nibble_stage #(.NIB_W(NIB_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_nib   (mii_rxd),
    .fwd_en   (fwd_en),
    .side_nib (side_nib),
    .fifo_nib (fifo_nib),
    .fifo_vld (fifo_vld)
  );

  mii_delim_match #(.NIB_W(NIB_W), .DELIM(DELIM)) u_match (
    .hunt_req (sfd_hunt),
    .side_nib (side_nib),
    .det      (sfd_det)
  );

  mii_rx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_dv    (mii_rx_dv),
    .rx_er    (mii_rx_er),
    .det      (sfd_det),
    .hunt_req (sfd_hunt),
    .fwd_en   (fwd_en)
  );
endmodule

// File: tb/test_mii_rx_front.sv
`timescale 1ns/1ps
module test_mii_rx_front;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] mii_rxd;
  logic       mii_rx_dv, mii_rx_er;
  logic [3:0] side_nib, fifo_nib;
  logic       fifo_vld, sfd_det, sfd_hunt;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 0, done = 0;
  logic [3:0] got[$];
  int det_cnt, side_bad, zero_bad, hunt_bad, pulse_bad;
  logic prev_det;

  always #2.5 clk = ~clk;

  mii_rx_front i_mii_rx_front (
    .clk(clk), .rst_n(rst_n), .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv),
    .mii_rx_er(mii_rx_er), .side_nib(side_nib), .fifo_nib(fifo_nib),
    .fifo_vld(fifo_vld), .sfd_det(sfd_det), .sfd_hunt(sfd_hunt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pre_nib();
    logic [3:0] n = 4'($urandom);
    return (n == 4'b1011) ? 4'b1010 : n;
  endfunction

  task automatic send(input logic [3:0] n, input logic dv, input logic er);
    @(negedge clk);
    mii_rxd = n; mii_rx_dv = dv; mii_rx_er = er;
  endtask

  // monitor: 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (side_nib !== mii_rxd) side_bad++;
      if (!fifo_vld && fifo_nib !== 4'd0) zero_bad++;
      if (sfd_det && !sfd_hunt) hunt_bad++;
      if (sfd_det && prev_det) pulse_bad++;
      if (prev_det && sfd_hunt) pulse_bad++;
      if (sfd_det) det_cnt++;
      if (fifo_vld) got.push_back(fifo_nib);
      prev_det = sfd_det;
    end
  end

  task automatic clear_mon();
    got.delete();
    det_cnt = 0; side_bad = 0; zero_bad = 0; hunt_bad = 0; pulse_bad = 0;
  endtask

  // pre: preamble nibbles; err_at: payload index with error (-1 none)
  // cut: valid drops during hunt; pre_err: error on last preamble nibble
  task automatic run_frame(input int pre, input int len, input int err_at,
                           input bit cut, input bit pre_err, input string tag);
    logic [3:0] exp_q[$];
    int exp_det, mism;
    clear_mon();
    for (int i = 0; i < pre; i++)
      send((i == 0 && pre > 3) ? 4'b1010 : pre_nib(), 1'b1, pre_err && (i == pre - 1));
    if (cut) begin
      exp_det = 0;
    end else begin
      send(4'b1011, 1'b1, 1'b0);
      exp_det = pre_err ? 0 : 1;
      for (int i = 0; i < len; i++) begin
        logic [3:0] p = 4'($urandom);
        if (!pre_err && (err_at < 0 || i < err_at)) exp_q.push_back(p);
        send(p, 1'b1, (i == err_at));
      end
    end
    send(4'b1011, 1'b0, 1'b0);
    send(4'($urandom), 1'b0, 1'b0);
    send(4'b1011, 1'b0, 1'b0);
    @(negedge clk);
    mism = 0;
    if (got.size() == exp_q.size())
      for (int i = 0; i < got.size(); i++) if (got[i] !== exp_q[i]) mism++;
    chk(got.size() == exp_q.size(), {"R6 count ", tag}, got.size(), exp_q.size());
    chk(mism == 0, {"R6 order ", tag}, mism, 0);
    chk(det_cnt == exp_det, {"R5 det ", tag}, det_cnt, exp_det);
    chk(pulse_bad == 0, {"R5 pulse ", tag}, pulse_bad, 0);
    chk(side_bad == 0, {"R2 side ", tag}, side_bad, 0);
    chk(zero_bad == 0, {"R3 zero ", tag}, zero_bad, 0);
    chk(hunt_bad == 0, {"R4 hunt ", tag}, hunt_bad, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5eed_1234);
    prev_det = 0;
    rst_n = 1'b0; mii_rxd = 4'b1011; mii_rx_dv = 1'b1; mii_rx_er = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state with active-looking inputs
    chk(side_nib == 0 && fifo_nib == 0, "R1 data", {side_nib, fifo_nib}, 0);
    chk(!fifo_vld && !sfd_det && !sfd_hunt, "R1 flags", {fifo_vld, sfd_det, sfd_hunt}, 0);
    @(negedge clk);
    mii_rx_dv = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(side_nib == 0 && !fifo_vld && !sfd_hunt, "R1 sync hold", {side_nib, fifo_vld, sfd_hunt}, 0);
    repeat (3) @(posedge clk);
    mon_on = 1;

    // R4: delimiter while idle
    clear_mon();
    repeat (6) send(4'b1011, 1'b0, 1'b0);
    @(negedge clk);
    chk(det_cnt == 0 && got.size() == 0, "R4 idle 1011", det_cnt, 0);

    run_frame(7, 12, -1, 0, 0, "R6 basic");
    run_frame(0, 5, -1, 0, 0, "R6 no preamble");
    run_frame(4, 0, -1, 0, 0, "R8 empty payload");
    run_frame(6, 8, 0, 0, 0, "R7 err first");
    run_frame(6, 10, 3, 0, 0, "R7 err mid");
    run_frame(5, 10, 9, 0, 0, "R7 err last");
    run_frame(5, 6, -1, 1, 0, "R9 cut hunt");
    run_frame(5, 6, -1, 0, 0, "R9 after cut");
    run_frame(5, 6, -1, 0, 1, "R7 err hunt");

    for (int k = 0; k < 40; k++) begin
      int pre = $urandom_range(0, 15);
      int len = $urandom_range(0, 40);
      int ea  = ($urandom_range(0, 3) == 0 && len > 0) ? $urandom_range(0, len - 1) : -1;
      bit cut = ($urandom_range(0, 7) == 0);
      run_frame(pre, len, ea, cut, 0, "R6 random");
    end
    finish_run();
  end
endmodule